// File: doc/BRIEF.md
# Writeback Trace Serializer

This block sits beside the CPU's writeback stage. Every instruction that retires offers one trace record: the instruction address, the destination register index, the result value and a small info field. The block latches each offered record into a capture register, queues it in a small FIFO, and drains the FIFO one record at a time. Each drained record becomes a fixed frame of bytes, and a UART transmitter shifts that frame out on a single serial line.

The FIFO has a fixed depth and the serial link is much slower than the core. For that reason the block drives a stall line back to the writeback stage, and a record is taken only in a cycle where the record is offered and stall is low. A host on the other end of the line can find record boundaries by the sync byte and decode the fields at fixed offsets.

Top module: `trace_serializer`

## Requirements
- R1: While reset is held and right after it is released, `uart_tx_o` is high (idle) and `trc_stall_o` is low.
- R2: A record is taken only at a rising clock edge where `trc_valid_i` is high and `trc_stall_o` is low. Values offered while stall is high never show up on the serial line.
- R3: Each record is sent as 11 bytes in this order: sync byte 0xA5; the address as 4 bytes, least significant byte first; one byte {3'b000, destination}; the result as 4 bytes, least significant byte first; one byte {3'b000, info}. Records go out in the order they were taken.
- R4: Each byte is sent as one low start bit, 8 data bits with the least significant bit first, and one high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles.
- R5: Within a record, the start bit of each byte begins exactly `10*CLKS_PER_BIT` cycles after the start bit of the byte before it.
- R6: When another record is already queued at the moment a record's last stop bit ends, that record's sync byte starts in the next bit slot, with no idle time between them.
- R7: With nothing queued or in flight, `uart_tx_o` stays high.
- R8: Stall goes high when the FIFO is full, or when it is one entry short of full and the capture register holds a record. Starting from an empty block, a continuous stream of valid records (depth 8) is accepted for exactly 9 cycles: one record moves into the framer and 8 fill the FIFO. Stall then stays high until the FIFO drains an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trc_valid_i | input | 1 | A record is offered this cycle |
| trc_pc_i | input | 32 | Instruction address of the record |
| trc_rd_i | input | 5 | Destination register index |
| trc_result_i | input | 32 | Result written back |
| trc_info_i | input | 5 | Instruction info bits |
| trc_stall_o | output | 1 | Asks the writeback stage to hold |
| uart_tx_o | output | 1 | Serial output, 8N1 framing, idles high |

## Verification
The assertions check on every cycle that the FIFO is never pushed while full and never popped while empty, and that the frame byte index stays within the 11-byte frame. They also check that the line is high whenever the transmitter is idle, that a load into the transmitter drives a start bit on the next cycle, and that an asserted stall persists while no entry is drained. Some behaviour can only be shown by the bench's scenarios, which decode the serial line against a queue of the records it handed over. That covers the byte order and field packing, the bit timing, the lack of gaps between bytes and between queued records, the exact number of records accepted in a burst, and the fact that values offered during stall are dropped.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef struct packed {
    logic [31:0] pc;
    logic [4:0]  rd;
    logic [31:0] res;
    logic [4:0]  info;
  } trc_rec_t;

  localparam int unsigned REC_W       = $bits(trc_rec_t);
  localparam int unsigned FRAME_BYTES = 11;
  localparam logic [7:0]  SYNC_BYTE   = 8'hA5;

  function automatic logic [7:0] frame_byte(trc_rec_t r, logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = SYNC_BYTE;
      4'd1:    b = r.pc[7:0];
      4'd2:    b = r.pc[15:8];
      4'd3:    b = r.pc[23:16];
      4'd4:    b = r.pc[31:24];
      4'd5:    b = {3'b000, r.rd};
      4'd6:    b = r.res[7:0];
      4'd7:    b = r.res[15:8];
      4'd8:    b = r.res[23:16];
      4'd9:    b = r.res[31:24];
      4'd10:   b = {3'b000, r.info};
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 74
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             afull_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop_i)  rp_q <= ptr_inc(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign afull_o = (cnt_q == CW'(DEPTH - 1));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/trace_framer.sv
module trace_framer
  import trace_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trc_rec_t rec_i,
  input  logic     empty_i,
  output logic     pop_o,
  output logic [7:0] byte_o,
  output logic     byte_vld_o,
  input  logic     byte_rdy_i
);
  localparam logic [3:0] LAST = 4'(FRAME_BYTES - 1);

  trc_rec_t   rec_q;
  logic       busy_q;
  logic [3:0] idx_q;
  logic       take, last;

  assign take  = byte_vld_o && byte_rdy_i;
  assign last  = (idx_q == LAST);
  // refill in the same cycle the last byte is taken, so records run back to back
  assign pop_o = !empty_i && (!busy_q || (take && last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (pop_o) begin
      rec_q  <= rec_i;
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (take) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign byte_vld_o = busy_q;
  assign byte_o     = frame_byte(rec_q, idx_q);

  // R3
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
endmodule

// File: rtl/trace_uart_tx.sv
module trace_uart_tx #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       vld_i,
  output logic       rdy_o,
  output logic       tx_o
);
  localparam int unsigned CCW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic           busy_q;
  logic [9:0]     sh_q;
  logic [3:0]     bit_q;
  logic [CCW-1:0] clk_q;
  logic           end_bit, last_bit, load;

  assign end_bit  = (clk_q == CCW'(CLKS_PER_BIT - 1));
  assign last_bit = (bit_q == 4'd9);
  assign rdy_o    = !busy_q || (end_bit && last_bit);
  assign load     = vld_i && rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      clk_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, byte_i, 1'b0};
      bit_q  <= '0;
      clk_q  <= '0;
    end else if (busy_q) begin
      if (end_bit) begin
        clk_q <= '0;
        sh_q  <= {1'b1, sh_q[9:1]};
        if (last_bit) busy_q <= 1'b0;
        else          bit_q  <= bit_q + 1'b1;
      end else begin
        clk_q <= clk_q + 1'b1;
      end
    end
  end

  assign tx_o = sh_q[0];

  // R7
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_o);
  // R4
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !tx_o);
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
  import trace_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned FIFO_DEPTH   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        trc_valid_i,
  input  logic [31:0] trc_pc_i,
  input  logic [4:0]  trc_rd_i,
  input  logic [31:0] trc_result_i,
  input  logic [4:0]  trc_info_i,
  output logic        trc_stall_o,
  output logic        uart_tx_o
);
  trc_rec_t   cap_q, fifo_out;
  logic       cap_vld_q, capture;
  logic       fifo_pop, fifo_empty, fifo_full, fifo_afull;
  logic [7:0] tx_byte;
  logic       tx_vld, tx_rdy;

  // pending capture counts against the last free slot
  assign trc_stall_o = fifo_full || (fifo_afull && cap_vld_q);
  assign capture     = trc_valid_i && !trc_stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      cap_q     <= '0;
    end else begin
      cap_vld_q <= capture;
      if (capture) cap_q <= '{pc: trc_pc_i, rd: trc_rd_i, res: trc_result_i, info: trc_info_i};
    end
  end

  trace_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REC_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cap_vld_q),
    .wdata_i (cap_q),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_out),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .afull_o (fifo_afull)
  );

  trace_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rec_i      (fifo_out),
    .empty_i    (fifo_empty),
    .pop_o      (fifo_pop),
    .byte_o     (tx_byte),
    .byte_vld_o (tx_vld),
    .byte_rdy_i (tx_rdy)
  );

  trace_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (tx_byte),
    .vld_i  (tx_vld),
    .rdy_o  (tx_rdy),
    .tx_o   (uart_tx_o)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trc_stall_o && !fifo_pop) |=> trc_stall_o);
endmodule

// File: tb/trace_serializer_tb.sv
module trace_serializer_tb;
  import trace_pkg::*;

  localparam int CPB   = 4;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] pc = '0;
  logic [4:0]  rd = '0;
  logic [31:0] res = '0;
  logic [4:0]  info = '0;
  logic        stall, tx;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  trc_rec_t exp_q[$];

  localparam trc_rec_t VEC [6] = '{
    '{32'h0000_1000, 5'd1,  32'h1234_5678, 5'd0},
    '{32'hFFFF_FFFC, 5'd31, 32'hFFFF_FFFF, 5'd31},
    '{32'h0000_0000, 5'd0,  32'h0000_0000, 5'd0},
    '{32'h8000_0004, 5'd10, 32'hA5A5_A5A5, 5'd5},
    '{32'hDEAD_BEE0, 5'd17, 32'h0102_0304, 5'd18},
    '{32'h0040_0020, 5'd2,  32'h8000_0001, 5'd1}
  };

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trace_serializer #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trc_valid_i(valid), .trc_pc_i(pc),
    .trc_rd_i(rd), .trc_result_i(res), .trc_info_i(info),
    .trc_stall_o(stall), .uart_tx_o(tx)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // hold a record until taken (R2)
  task automatic send_rec(input trc_rec_t r);
    @(negedge clk);
    valid = 1'b1; pc = r.pc; rd = r.rd; res = r.res; info = r.info;
    while (stall) @(negedge clk);
    exp_q.push_back(r);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // serial line decoder
  initial begin
    logic [7:0] bytes [FRAME_BYTES];
    int nb = 0;
    int last_end = 0;
    bit cont = 1'b0;
    int rec_no = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !tx) begin
        int n0;
        logic [7:0] b;
        n0 = cyc;
        if (cont) begin
          // R5 within a record, R6 across queued records
          chk(n0 == last_end, (nb == 0) ? "R6" : "R5",
              $sformatf("start at cycle %0d, expected %0d", n0, last_end));
        end
        repeat (CPB/2) @(negedge clk);
        chk(!tx, "R4", $sformatf("start bit mid got %0b exp 0", tx));
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        chk(tx, "R4", $sformatf("stop bit got %0b exp 1", tx));
        repeat (CPB - CPB/2 - 1) @(negedge clk);
        last_end = n0 + 10*CPB;
        bytes[nb] = b;
        nb++;
        if (nb == FRAME_BYTES) begin
          trc_rec_t got, e;
          got.pc   = {bytes[4], bytes[3], bytes[2], bytes[1]};
          got.rd   = bytes[5][4:0];
          got.res  = {bytes[9], bytes[8], bytes[7], bytes[6]};
          got.info = bytes[10][4:0];
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "record decoded with none expected");
          end else begin
            e = exp_q.pop_front();
            chk(bytes[0] == SYNC_BYTE && bytes[5][7:5] == 3'b0 && bytes[10][7:5] == 3'b0 && got == e,
                "R3", $sformatf("rec %0d got sync=%h pc=%h rd=%0d res=%h info=%0d exp pc=%h rd=%0d res=%h info=%0d",
                rec_no, bytes[0], got.pc, got.rd, got.res, got.info, e.pc, e.rd, e.res, e.info));
          end
          rec_no++;
          nb = 0;
          cont = (exp_q.size() != 0);
        end else begin
          cont = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish, got timeout exp completion");
    finish_run();
  end

  initial begin
    int acc;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && stall === 1'b0, "R1",
        $sformatf("in reset tx=%b stall=%b exp 1/0", tx, stall));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx === 1'b1 && stall === 1'b0, "R1",
        $sformatf("after reset tx=%b stall=%b exp 1/0", tx, stall));

    // table walk: queued back to back (R3, R5, R6)
    for (int i = 0; i < 6; i++) send_rec(VEC[i]);
    drain();

    // spaced records: second arrives mid-frame
    send_rec(VEC[1]);
    repeat (50) @(negedge clk);
    send_rec(VEC[3]);
    drain();

    // R8 burst from empty, data changing every cycle; stalled values must vanish (R2)
    acc = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      valid = 1'b1;
      pc = 32'h2000_0000 + 32'(k*4); rd = 5'(k); res = ~32'(k); info = 5'(k+3);
      if (!stall) begin
        exp_q.push_back('{pc: pc, rd: rd, res: res, info: info});
        acc++;
      end
    end
    @(negedge clk);
    valid = 1'b0;
    chk(acc == DEPTH + 1, "R8", $sformatf("burst accepted %0d exp %0d", acc, DEPTH + 1));
    chk(stall === 1'b1, "R8", $sformatf("stall after burst %b exp 1", stall));
    drain();
    chk(stall === 1'b0, "R8", $sformatf("stall after drain %b exp 0", stall));

    // R7 idle line
    begin
      bit all_high = 1'b1;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (tx !== 1'b1) all_high = 1'b0;
      end
      chk(all_high, "R7", $sformatf("idle line saw low, exp high"));
    end
    chk(exp_q.size() == 0, "R3", $sformatf("records left %0d exp 0", exp_q.size()));
    finish_run();
  end
endmodule